// File: doc/BRIEF.md
# Floating-Point Status and Control Word Unit

This block holds the two 16-bit words that describe the state of a floating-point coprocessor. The status word contains the busy bit, the stack-top index, four condition-code bits, the error-summary bit and six sticky exception flags. The control word contains one mask per exception and the precision and rounding selections. The execution unit reports exception events, condition codes, compare outcomes and stack-top changes. The host loads the control word and reads the status word at any time. Reading has no side effect, and the busy bit is not involved in a read.

Once an exception flag is set, it stays set until an explicit clear command or a reset. The error-summary bit is the OR of every flag whose mask is clear. That bit drives the external error output directly, so writing a new mask has an effect one cycle later.

The busy bit comes from a two-state machine. In state `ST_IDLE` the bit reads 0. The transition `go_run` moves the machine to `ST_RUN` when `busy_i` is sampled high. In `ST_RUN` the bit reads 1. The transition `go_idle` returns the machine to `ST_IDLE` when `busy_i` is sampled low. Reset places the machine in `ST_IDLE`.

Top module: `fpsw_unit`

## Requirements
- R1: After reset `status_o` is 0x0000, `control_o` is 0x037F, `error_o` is 0, `prec_o` is 2'b11 and `round_o` is 2'b00.
- R2: The status word layout is as follows:
  - bit 15 is busy;
  - bits 14:12 are the stack-top index;
  - bit 11 is C3, bit 10 is C2, bit 9 is C1 and bit 8 is C0;
  - bit 7 is the error summary;
  - bit 6 reads 0;
  - bits 5:0 are the flags, in this order: invalid (0), denormal (1), zero divide (2), overflow (3), underflow (4), inexact (5).
- R3: When `exc_valid` is high, each bit of `exc_events` is ORed into the matching flag on the next edge. Flags are never cleared by events.
- R4: A `clr_exc` pulse clears all six flags on the next edge. Events presented in the same cycle as the clear are kept.
- R5: `error_o` and status bit 7 are 1 exactly when some flag is set while its mask bit `control_o[i]` is 0. Both bits reflect any change to a flag or a mask one cycle after that change is presented.
- R6: A `cw_wr` pulse loads `cw_i` into `control_o` on the next edge. Bits 5:0 of the control word are the masks, at the same positions as the flags.
- R7: `prec_o` equals control bits 9:8, with 00 selecting 24 bits, 01 reserved, 10 selecting 53 bits and 11 selecting 64 bits. `round_o` equals control bits 11:10, with 00 selecting nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero.
- R8: A `cmp_wr` pulse with `cmp_res` sets {C3,C2,C0} and leaves C1 unchanged:
  - 00 (greater) gives 000;
  - 01 (less) gives 001;
  - 10 (equal) gives 100;
  - 11 (unordered) gives 111.
- R9: A `cc_wr` pulse loads `cc_i[3:0]` into {C3,C2,C1,C0}. It takes precedence over a compare update in the same cycle.
- R10: A `top_wr` pulse loads `top_i` into status bits 14:12 on the next edge. No other stimulus alters the stack-top index.
- R11: Status bit 15 follows `busy_i` one cycle later, as described by the `ST_IDLE` and `ST_RUN` states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Execution unit is running an instruction |
| exc_valid | input | 1 | Exception event vector is valid |
| exc_events | input | 6 | Exception events, in flag order |
| clr_exc | input | 1 | Clear all exception flags |
| top_wr | input | 1 | Load stack-top index |
| top_i | input | 3 | New stack-top index |
| cc_wr | input | 1 | Load all four condition codes |
| cc_i | input | 4 | New {C3,C2,C1,C0} |
| cmp_wr | input | 1 | Apply a compare outcome |
| cmp_res | input | 2 | Compare outcome code |
| cw_wr | input | 1 | Load control word |
| cw_i | input | 16 | New control word |
| status_o | output | 16 | Status word |
| control_o | output | 16 | Control word |
| error_o | output | 1 | External error, equal to the error summary |
| prec_o | output | 2 | Precision selection |
| round_o | output | 2 | Rounding selection |

## Verification
The bench builds the block with its default parameters: six exceptions and a reset control word of 0x037F. With these values, the bench can unmask each flag position in turn and walk every precision and rounding code. It also drives all four compare outcomes, and it exercises a clear that arrives in the same cycle as new events.

// File: rtl/fpsw_pkg.sv
package fpsw_pkg;
    localparam int WORD_W  = 16;
    localparam int NUM_EXC = 6;
    localparam int TOP_W   = 3;
    localparam int CC_W    = 4;

    localparam int BIT_BUSY = 15;
    localparam int BIT_ES   = 7;
    localparam int PREC_LO  = 8;
    localparam int RND_LO   = 10;

    typedef enum logic [1:0] {
        CMP_GT = 2'b00,
        CMP_LT = 2'b01,
        CMP_EQ = 2'b10,
        CMP_UN = 2'b11
    } cmp_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_e;
endpackage

// File: rtl/fpsw_busy_fsm.sv
module fpsw_busy_fsm
    import fpsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    output logic busy_o
);
    run_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (busy_i)  state_d = ST_RUN;   // go_run
            ST_RUN:  if (!busy_i) state_d = ST_IDLE;  // go_idle
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  busy_o = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end

    // R11
    busy_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> busy_o);
endmodule

// File: rtl/fpsw_ctrl_reg.sv
module fpsw_ctrl_reg #(
    parameter int          W   = 16,
    parameter logic [15:0] RST = 16'h037F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    output logic [W-1:0] cw_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)  cw_q <= RST[W-1:0];
        else if (wr) cw_q <= din;
    end

    // R6
    cw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cw_q == $past(din)));

    // R6
    cw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(cw_q));
endmodule

// File: rtl/fpsw_flags.sv
module fpsw_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ev_valid,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] masks,
    output logic [N-1:0] flags_q,
    output logic         es_o
);
    logic [N-1:0] live;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) flags_q[i] <= 1'b0;
            else        flags_q[i] <= (flags_q[i] & ~clr) | (ev_valid & ev[i]);
        end
        assign live[i] = flags_q[i] & ~masks[i];
    end

    assign es_o = |live;

    // R3
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R4
    clr_keeps_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev_valid) |=> (flags_q == '0));
endmodule

// File: rtl/fpsw_cc.sv
module fpsw_cc
    import fpsw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cc_wr,
    input  logic [CC_W-1:0]  cc_i,
    input  logic             cmp_wr,
    input  cmp_e             cmp_res,
    input  logic             top_wr,
    input  logic [TOP_W-1:0] top_i,
    output logic [CC_W-1:0]  cc_q,
    output logic [TOP_W-1:0] top_q
);
    logic [2:0] cmp_code;

    always_comb begin
        unique case (cmp_res)
            CMP_GT:  cmp_code = 3'b000;
            CMP_LT:  cmp_code = 3'b001;
            CMP_EQ:  cmp_code = 3'b100;
            default: cmp_code = 3'b111;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q <= '0;
        end else if (cc_wr) begin
            cc_q <= cc_i;
        end else if (cmp_wr) begin
            cc_q[3] <= cmp_code[2];
            cc_q[2] <= cmp_code[1];
            cc_q[0] <= cmp_code[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      top_q <= '0;
        else if (top_wr) top_q <= top_i;
    end

    // R8
    c1_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && !cc_wr) |=> $stable(cc_q[1]));

    // R10
    top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !top_wr |=> $stable(top_q));
endmodule

// File: rtl/fpsw_unit.sv
module fpsw_unit
    import fpsw_pkg::*;
#(
    parameter logic [15:0] CW_RESET = 16'h037F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              exc_valid,
    input  logic [NUM_EXC-1:0] exc_events,
    input  logic              clr_exc,
    input  logic              top_wr,
    input  logic [TOP_W-1:0]  top_i,
    input  logic              cc_wr,
    input  logic [CC_W-1:0]   cc_i,
    input  logic              cmp_wr,
    input  logic [1:0]        cmp_res,
    input  logic              cw_wr,
    input  logic [WORD_W-1:0] cw_i,
    output logic [WORD_W-1:0] status_o,
    output logic [WORD_W-1:0] control_o,
    output logic              error_o,
    output logic [1:0]        prec_o,
    output logic [1:0]        round_o
);
    logic               busy_bit;
    logic [NUM_EXC-1:0] flags;
    logic               es;
    logic [CC_W-1:0]    cc;
    logic [TOP_W-1:0]   top;
    cmp_e               cmp_sel;

    assign cmp_sel = cmp_e'(cmp_res);

    fpsw_busy_fsm u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (busy_i),
        .busy_o (busy_bit)
    );

    fpsw_ctrl_reg #(.W(WORD_W), .RST(CW_RESET)) u_cw (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cw_wr),
        .din   (cw_i),
        .cw_q  (control_o)
    );

    fpsw_flags #(.N(NUM_EXC)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_exc),
        .ev_valid (exc_valid),
        .ev       (exc_events),
        .masks    (control_o[NUM_EXC-1:0]),
        .flags_q  (flags),
        .es_o     (es)
    );

    fpsw_cc u_cc (
        .clk     (clk),
        .rst_n   (rst_n),
        .cc_wr   (cc_wr),
        .cc_i    (cc_i),
        .cmp_wr  (cmp_wr),
        .cmp_res (cmp_sel),
        .top_wr  (top_wr),
        .top_i   (top_i),
        .cc_q    (cc),
        .top_q   (top)
    );

    assign status_o = {busy_bit, top, cc[3], cc[2], cc[1], cc[0], es, 1'b0, flags};
    assign error_o  = status_o[BIT_ES];
    assign prec_o   = control_o[PREC_LO+1:PREC_LO];
    assign round_o  = control_o[RND_LO+1:RND_LO];

    // R5
    error_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error_o == |(status_o[NUM_EXC-1:0] & ~control_o[NUM_EXC-1:0]));

    // R2
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6] == 1'b0);
endmodule

// File: tb/test_fpsw_unit.sv
module test_fpsw_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        busy_i, exc_valid, clr_exc, top_wr, cc_wr, cmp_wr, cw_wr;
    logic [5:0]  exc_events;
    logic [2:0]  top_i;
    logic [3:0]  cc_i;
    logic [1:0]  cmp_res;
    logic [15:0] cw_i;
    logic [15:0] status_o, control_o;
    logic        error_o;
    logic [1:0]  prec_o, round_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    fpsw_unit i_fpsw_unit (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .exc_valid(exc_valid),
        .exc_events(exc_events), .clr_exc(clr_exc), .top_wr(top_wr), .top_i(top_i),
        .cc_wr(cc_wr), .cc_i(cc_i), .cmp_wr(cmp_wr), .cmp_res(cmp_res),
        .cw_wr(cw_wr), .cw_i(cw_i), .status_o(status_o), .control_o(control_o),
        .error_o(error_o), .prec_o(prec_o), .round_o(round_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        exc_valid = 0; exc_events = '0; clr_exc = 0; top_wr = 0; top_i = '0;
        cc_wr = 0; cc_i = '0; cmp_wr = 0; cmp_res = '0; cw_wr = 0; cw_i = '0;
    endtask

    // one cycle: inputs set at negedge, cleared at next negedge, result visible then
    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        chk("R1 status", status_o, 16'h0000);
        chk("R1 control", control_o, 16'h037F);
        chk("R1 error", {15'd0, error_o}, 16'd0);
        chk("R1 prec", {14'd0, prec_o}, 16'd3);
        chk("R1 round", {14'd0, round_o}, 16'd0);
    endtask

    task automatic t_sticky();
        exc_valid = 1; exc_events = 6'b000100; step();
        chk("R3 first event", {10'd0, status_o[5:0]}, 16'h0004);
        exc_valid = 1; exc_events = 6'b100001; step();
        chk("R3 accumulate", {10'd0, status_o[5:0]}, 16'h0025);
        exc_valid = 0; exc_events = 6'b010000; step();
        chk("R3 invalid ignored", {10'd0, status_o[5:0]}, 16'h0025);
        chk("R5 all masked", {15'd0, error_o}, 16'd0);
    endtask

    task automatic t_mask_error();
        cw_i = 16'h037E; cw_wr = 1; step();      // unmask invalid (bit 0)
        chk("R6 control load", control_o, 16'h037E);
        chk("R5 unmask raises error", {15'd0, error_o}, 16'd1);
        chk("R2 es bit", {15'd0, status_o[7]}, 16'd1);
        cw_i = 16'h037F; cw_wr = 1; step();
        chk("R5 remask drops error", {15'd0, error_o}, 16'd0);
        for (int i = 0; i < 6; i++) begin
            clr_exc = 1; step();
            cw_i = 16'h0340 | (16'h003F & ~(16'd1 << i)); cw_wr = 1; step();
            chk("R5 no flag no error", {15'd0, error_o}, 16'd0);
            exc_valid = 1; exc_events = 6'd1 << i; step();
            chk("R2 flag position", {10'd0, status_o[5:0]}, 16'd1 << i);
            chk("R5 error per bit", {15'd0, error_o}, 16'd1);
        end
        cw_i = 16'h037F; cw_wr = 1; step();
    endtask

    task automatic t_clear();
        exc_valid = 1; exc_events = 6'b111111; step();
        clr_exc = 1; step();
        chk("R4 clear", {10'd0, status_o[5:0]}, 16'h0000);
        exc_valid = 1; exc_events = 6'b001000; step();
        clr_exc = 1; exc_valid = 1; exc_events = 6'b000010; step();
        chk("R4 same-cycle event kept", {10'd0, status_o[5:0]}, 16'h0002);
        clr_exc = 1; step();
    endtask

    task automatic t_fields();
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 4; r++) begin
                cw_i = 16'h003F | 16'(p << 8) | 16'(r << 10); cw_wr = 1; step();
                chk("R7 prec", {14'd0, prec_o}, 16'(p));
                chk("R7 round", {14'd0, round_o}, 16'(r));
            end
        end
        cw_i = 16'hABCD; cw_wr = 0; step();
        chk("R6 no write keeps", control_o, 16'h0F3F);
        cw_i = 16'h037F; cw_wr = 1; step();
    endtask

    task automatic t_compare();
        cc_i = 4'b0010; cc_wr = 1; step();      // C1 = 1
        chk("R9 cc load", {12'd0, status_o[11:8]}, 16'h2);
        cmp_res = 2'b00; cmp_wr = 1; step();
        chk("R8 greater", {12'd0, status_o[11:8]}, 16'h2);
        cmp_res = 2'b01; cmp_wr = 1; step();
        chk("R8 less", {12'd0, status_o[11:8]}, 16'h3);
        cmp_res = 2'b10; cmp_wr = 1; step();
        chk("R8 equal", {12'd0, status_o[11:8]}, 16'hA);
        cmp_res = 2'b11; cmp_wr = 1; step();
        chk("R8 unordered", {12'd0, status_o[11:8]}, 16'hF);
        cc_i = 4'b0000; cc_wr = 1; cmp_res = 2'b11; cmp_wr = 1; step();
        chk("R9 precedence", {12'd0, status_o[11:8]}, 16'h0);
        cmp_res = 2'b11; cmp_wr = 1; step();
        chk("R8 unordered C1 clear kept", {12'd0, status_o[11:8]}, 16'hD);
    endtask

    task automatic t_top();
        top_i = 3'd5; top_wr = 1; step();
        chk("R10 top load", {13'd0, status_o[14:12]}, 16'd5);
        top_i = 3'd2; top_wr = 0; step();
        chk("R10 top hold", {13'd0, status_o[14:12]}, 16'd5);
        top_i = 3'd7; top_wr = 1; step();
        chk("R10 top seven", {13'd0, status_o[14:12]}, 16'd7);
    endtask

    task automatic t_busy();
        @(negedge clk); busy_i = 1;
        chk("R11 busy not yet", {15'd0, status_o[15]}, 16'd0);
        @(negedge clk);
        chk("R11 busy set", {15'd0, status_o[15]}, 16'd1);
        @(negedge clk);
        chk("R11 busy held", {15'd0, status_o[15]}, 16'd1);
        busy_i = 0;
        @(negedge clk);
        chk("R11 busy cleared", {15'd0, status_o[15]}, 16'd0);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; busy_i = 0; idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_sticky();
        t_mask_error();
        t_clear();
        t_fields();
        t_compare();
        t_top();
        t_busy();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule